// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup

This block is the lookup path of a small set-associative data cache. When a load arrives, its virtual address selects a set at once. Only address bits that sit inside the page offset are used for that choice, and those bits are identical in the virtual and physical forms of the address. While the tag and data arrays are being read, an external translation unit works out the physical page number. One cycle later it hands that number, together with a fault flag, to this block.

In the second cycle the block compares every way's stored tag against the physical page number. It then registers one of three results: a hit with the addressed word, a miss, or a translation fault. The tag is the full physical page number, so two virtual aliases of the same physical location find the same line. Misses are repaired through a fill port, which writes a whole line and its tag. The target way comes from a round-robin pointer kept for each set.

The number of sets is limited by the page size, because the set index and the line offset together must fit inside the page offset. To grow capacity, the design adds ways rather than sets.

Top module: `vipt_lookup`

## Requirements
- R1: The set is taken from `req_vaddr[11:6]` and the word from `req_vaddr[5:2]`. Word n of a line occupies bits `[32n+31:32n]` of `fill_line`. Elaboration fails if set-index bits plus line-offset bits exceed page-offset bits.
- R2: A request accepted at clock edge k produces a response at edge k+1. The translation inputs are sampled at edge k+1. `rsp_valid` is high for exactly one cycle and only follows a request.
- R3: A hit is reported when a valid way of the selected set holds a tag equal to `xlat_ppn`. `rsp_way` gives that way and `rsp_data` gives the addressed word.
- R4: A miss is reported when no valid way of the set matches. After reset, every lookup misses.
- R5: Two virtual addresses with different page numbers but the same page offset both hit the same line when they translate to the same physical page.
- R6: The same virtual address misses when translation returns a physical page number other than the stored one.
- R7: When `xlat_fault` is high, the response is a fault, with `rsp_hit` and `rsp_miss` both low, even if a tag would have matched.
- R8: If `xlat_valid` is low in the cycle after a request, that request produces no response.
- R9: A fill writes the line and tag into the set's round-robin way and marks it valid. Each set's pointer starts at way 0 after reset and advances by one, modulo the number of ways, on each fill to that set only.
- R10: When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. When it is low, all three are low.
- R11: Synchronous active-high reset clears `rsp_valid`, all valid bits and all round-robin pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_vaddr | input | 32 | Virtual address of the load |
| xlat_valid | input | 1 | Translation answer present (cycle after the request) |
| xlat_ppn | input | 20 | Physical page number from translation |
| xlat_fault | input | 1 | Translation fault |
| fill_valid | input | 1 | Line fill strobe |
| fill_set | input | 6 | Set being filled |
| fill_ppn | input | 20 | Physical tag of the filled line |
| fill_line | input | 512 | Full line data |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_fault | output | 1 | Translation fault reported |
| rsp_way | output | 2 | Way that hit |
| rsp_data | output | 32 | Addressed word on a hit |

## Verification
Lookups are run with several address and translation patterns. In one, the same virtual address is paired with the stored physical page and then with a foreign one; this shows that the tag compare uses the physical number and not the virtual one. In another, two virtual addresses that differ only in their page-number bits hit the same line, which shows that the upper virtual bits play no part in set selection. Nearby sets and different word offsets separate the index bits from the word-select bits. Repeated fills into one set expose the round-robin order and the eviction of the oldest line, and a single fill into a second set shows that each set keeps its own pointer. Faults and a missing translation answer are tested against lines that would otherwise hit.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_MISS  = 2'd1,
    RES_HIT   = 2'd2,
    RES_FAULT = 2'd3
  } res_e;
endpackage

// File: rtl/vipt_way_ram.sv
module vipt_way_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, read-first: inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vipt_rr_victim.sv
module vipt_rr_victim #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [SET_W-1:0] adv_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];

  assign victim = ptr_q[adv_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[adv_set] <= (ptr_q[adv_set] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[adv_set] + 1'b1;
    end
  end

  // R9: a fill moves the pointer of its set away from the way just written
  generate
    if (WAYS > 1) begin : g_rr_chk
      p_rr_moves_r9: assert property (@(posedge clk) disable iff (rst)
        adv |=> ptr_q[$past(adv_set)] != $past(victim));
    end
  endgenerate
endmodule

// File: rtl/vipt_hit_select.sv
module vipt_hit_select #(
  parameter int WAYS   = 4,
  parameter int PPN_W  = 20,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]   way_valid,
  input  logic [PPN_W-1:0]  way_tag  [WAYS],
  input  logic [LINE_W-1:0] way_line [WAYS],
  input  logic [PPN_W-1:0]  ppn,
  input  logic [WSEL_W-1:0] wsel,
  output logic [WAYS-1:0]   hit_vec,
  output logic              any_hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [WORD_W-1:0] hit_word
);
  always_comb begin
    hit_way  = '0;
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = way_valid[w] && (way_tag[w] == ppn);
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_word = way_line[w][wsel*WORD_W +: WORD_W];
      end
    end
    any_hit = |hit_vec;
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 6,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int PPN_W      = 20,
  parameter int WORD_W     = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = 8 * (1 << LINE_OFF_W),
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              xlat_valid,
  input  logic [PPN_W-1:0]  xlat_ppn,
  input  logic              xlat_fault,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [LINE_W-1:0] fill_line,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WORD_W-1:0] rsp_data
);
  import vipt_pkg::*;

  // R1: index and line offset must sit inside the page offset
  generate
    if (SET_W + LINE_OFF_W > PAGE_OFF_W) begin : g_bad_geometry
      $error("set index reaches past the page offset");
    end
  endgenerate

  // set and word come only from page-offset bits of the virtual address
  logic [SET_W-1:0]  req_set;
  logic [WSEL_W-1:0] req_wsel;
  logic              unused_va_bits;
  assign req_set  = req_vaddr[LINE_OFF_W +: SET_W];
  assign req_wsel = req_vaddr[BYTE_W +: WSEL_W];
  assign unused_va_bits = ^{req_vaddr[VA_W-1:LINE_OFF_W+SET_W], req_vaddr[BYTE_W-1:0]};

  // valid bits and victim choice
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAY_W-1:0] victim;

  vipt_rr_victim #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk(clk), .rst(rst), .adv(fill_valid), .adv_set(fill_set), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fill_valid) begin
      valid_q[fill_set][victim] <= 1'b1;
    end
  end

  // cycle 1: set read, in parallel with translation
  logic              s1_valid;
  logic [WSEL_W-1:0] s1_wsel;
  logic [WAYS-1:0]   s1_vld;
  logic [PPN_W-1:0]  tag_rd  [WAYS];
  logic [LINE_W-1:0] line_rd [WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_wsel  <= '0;
      s1_vld   <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_wsel <= req_wsel;
        s1_vld  <= valid_q[req_set];
      end
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic way_we;
      assign way_we = fill_valid && (victim == WAY_W'(w));

      vipt_way_ram #(.DEPTH(SETS), .WIDTH(PPN_W)) u_tag (
        .clk(clk), .we(way_we), .waddr(fill_set), .wdata(fill_ppn),
        .re(req_valid), .raddr(req_set), .rdata(tag_rd[w])
      );
      vipt_way_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) u_data (
        .clk(clk), .we(way_we), .waddr(fill_set), .wdata(fill_line),
        .re(req_valid), .raddr(req_set), .rdata(line_rd[w])
      );
    end
  endgenerate

  // cycle 2: physical tag compare
  logic [WAYS-1:0]   hit_vec;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WORD_W-1:0] hit_word;

  vipt_hit_select #(.WAYS(WAYS), .PPN_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_cmp (
    .way_valid(s1_vld), .way_tag(tag_rd), .way_line(line_rd), .ppn(xlat_ppn),
    .wsel(s1_wsel), .hit_vec(hit_vec), .any_hit(any_hit), .hit_way(hit_way),
    .hit_word(hit_word)
  );

  res_e res;
  always_comb begin
    if (!(s1_valid && xlat_valid)) res = RES_NONE;
    else if (xlat_fault)           res = RES_FAULT;
    else if (any_hit)              res = RES_HIT;
    else                           res = RES_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_way   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (res != RES_NONE);
      rsp_hit   <= (res == RES_HIT);
      rsp_miss  <= (res == RES_MISS);
      rsp_fault <= (res == RES_FAULT);
      rsp_way   <= hit_way;
      rsp_data  <= hit_word;
    end
  end

  // R10: one result kind per response, none without a response
  p_one_result_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
  // R2: a response always follows a request one edge earlier
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(s1_valid));
  // R3: a physical tag matches in at most one way
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && xlat_valid) |-> $onehot0(hit_vec));
  // R9: the filled way is valid afterwards
  p_fill_sets_valid_r9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> valid_q[$past(fill_set)][$past(victim)]);
endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         xlat_valid;
  logic [19:0]  xlat_ppn;
  logic         xlat_fault;
  logic         fill_valid;
  logic [5:0]   fill_set;
  logic [19:0]  fill_ppn;
  logic [511:0] fill_line;
  logic         rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [1:0]   rsp_way;
  logic [31:0]  rsp_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  vipt_lookup u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .xlat_fault(xlat_fault),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_ppn(fill_ppn),
    .fill_line(fill_line), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_way(rsp_way),
    .rsp_data(rsp_data)
  );

  localparam int K_NONE = 0, K_MISS = 1, K_HIT = 2, K_FAULT = 3;

  function automatic logic [31:0] mkword(input logic [23:0] seed, input int w);
    return {seed, 8'(w)};
  endfunction

  function automatic logic [31:0] va(input logic [19:0] vpn, input logic [5:0] set,
                                     input logic [3:0] word);
    return {vpn, set, word, 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [5:0] set, input logic [19:0] ppn,
                         input logic [23:0] seed);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_set   = set;
    fill_ppn   = ppn;
    for (int i = 0; i < 16; i++) fill_line[32*i +: 32] = mkword(seed, i);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] vaddr, input logic [19:0] ppn,
                        input bit fault, input bit xv, input int kind,
                        input logic [1:0] exp_way, input logic [31:0] exp_data,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = vaddr;
    @(posedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    xlat_valid = xv;
    xlat_ppn   = ppn;
    xlat_fault = fault;
    @(posedge clk);
    @(negedge clk);
    xlat_valid = 1'b0;
    xlat_fault = 1'b0;
    check(rsp_valid == (kind != K_NONE), req, 64'(rsp_valid), 64'(kind != K_NONE));
    check(rsp_hit == (kind == K_HIT), req, 64'(rsp_hit), 64'(kind == K_HIT));
    check(rsp_miss == (kind == K_MISS), req, 64'(rsp_miss), 64'(kind == K_MISS));
    check(rsp_fault == (kind == K_FAULT), req, 64'(rsp_fault), 64'(kind == K_FAULT));
    if (kind == K_HIT) begin
      check(rsp_way == exp_way, req, 64'(rsp_way), 64'(exp_way));
      check(rsp_data == exp_data, req, 64'(rsp_data), 64'(exp_data));
    end
    @(posedge clk);
    @(negedge clk);
    // R2 and R10: the response lasts one cycle
    check(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault, "R2 single-cycle R10",
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault}), 64'(0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 reset", 64'(rsp_valid), 64'(0));
    lookup(va(20'h00001, 6'd5, 4'd0), 20'hAAAAA, 0, 1, K_MISS, 0, 0, "R4 R11 empty");
  endtask

  task automatic t_fill_hit();
    do_fill(6'd5, 20'hAAAAA, 24'h000A01);
    lookup(va(20'h00001, 6'd5, 4'd3), 20'hAAAAA, 0, 1, K_HIT, 2'd0,
           mkword(24'h000A01, 3), "R3 R9 first fill");
  endtask

  task automatic t_alias();
    lookup(va(20'h7F00F, 6'd5, 4'd7), 20'hAAAAA, 0, 1, K_HIT, 2'd0,
           mkword(24'h000A01, 7), "R5 alias R1 word");
  endtask

  task automatic t_phys_tag();
    lookup(va(20'h00001, 6'd5, 4'd3), 20'hBBBBB, 0, 1, K_MISS, 0, 0, "R6 other ppn");
  endtask

  task automatic t_fault();
    lookup(va(20'h00001, 6'd5, 4'd3), 20'hAAAAA, 1, 1, K_FAULT, 0, 0, "R7 fault on match");
    lookup(va(20'h00002, 6'd6, 4'd0), 20'h12345, 1, 1, K_FAULT, 0, 0, "R7 fault on miss");
  endtask

  task automatic t_no_xlat();
    lookup(va(20'h00001, 6'd5, 4'd3), 20'hAAAAA, 0, 0, K_NONE, 0, 0, "R8 no translation");
  endtask

  task automatic t_round_robin();
    do_fill(6'd5, 20'hBBBBB, 24'h000B02);
    do_fill(6'd5, 20'hCCCCC, 24'h000C03);
    do_fill(6'd5, 20'hDDDDD, 24'h000D04);
    lookup(va(20'h00003, 6'd5, 4'd1), 20'hBBBBB, 0, 1, K_HIT, 2'd1,
           mkword(24'h000B02, 1), "R9 second way");
    lookup(va(20'h00003, 6'd5, 4'd2), 20'hDDDDD, 0, 1, K_HIT, 2'd3,
           mkword(24'h000D04, 2), "R9 fourth way");
    do_fill(6'd5, 20'hEEEEE, 24'h000E05);
    lookup(va(20'h00001, 6'd5, 4'd3), 20'hAAAAA, 0, 1, K_MISS, 0, 0, "R9 wrap evicts way0");
    lookup(va(20'h00001, 6'd5, 4'd0), 20'hEEEEE, 0, 1, K_HIT, 2'd0,
           mkword(24'h000E05, 0), "R9 wrap into way0");
    do_fill(6'd9, 20'hFFFFF, 24'h000F06);
    lookup(va(20'h00004, 6'd9, 4'd4), 20'hFFFFF, 0, 1, K_HIT, 2'd0,
           mkword(24'h000F06, 4), "R9 independent set pointer");
  endtask

  task automatic t_set_select();
    lookup(va(20'h00004, 6'd10, 4'd4), 20'hFFFFF, 0, 1, K_MISS, 0, 0, "R1 neighbour set");
    lookup(va(20'h00004, 6'd9, 4'd15), 20'hFFFFF, 0, 1, K_HIT, 2'd0,
           mkword(24'h000F06, 15), "R1 last word");
    lookup(va(20'h00004, 6'd5, 4'd15), 20'hCCCCC, 0, 1, K_HIT, 2'd2,
           mkword(24'h000C03, 15), "R3 third way");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; xlat_valid = 1'b0;
    xlat_ppn = '0; xlat_fault = 1'b0; fill_valid = 1'b0; fill_set = '0;
    fill_ppn = '0; fill_line = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_hit();
    t_alias();
    t_phys_tag();
    t_fault();
    t_no_xlat();
    t_round_robin();
    t_set_select();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule